// File: doc/BRIEF.md
# Codec Register Command Slot Bridge

This block sits between a CPU register port and the register access port of an audio codec. Software prepares a codec register command by writing two slot words. The slot-2 word carries the data to be written. The slot-1 word carries the direction bit and the codec register address, and writing it starts the command. The bridge then drives a request on the codec port and holds it until the codec acknowledges. For a read command, the bridge captures the returned data into two receive slot registers, and software fetches it from there.

A flags register lets software poll the progress of each slot. It shows whether the transmit slots are empty, whether a read is still outstanding, and whether the receive slots hold fresh data. Reading a receive slot marks it as consumed. All slot words are 20 bits wide and are zero-extended on the 32-bit register bus. The codec address field is 7 bits and the codec data is 16 bits.

Register map, on the 3-bit word address: 0 is the slot-1 transmit word (read/write), 1 is the slot-2 transmit word (read/write), 2 is the slot-1 receive word (read-only), 3 is the slot-2 receive word (read-only) and 4 is the flags register (read-only). Any other address reads as zero, and writes to it are dropped.

Top module: `ccb_top`

## Requirements
- R1: After reset, the flags register reads 0x07 and no codec request is pending. Flags bits: 0 = slot-1 transmit empty, 1 = slot-2 transmit empty, 2 = both transmit slots empty, 3 = slot-1 receive valid, 4 = slot-2 receive valid, 5 = slot-1 receive busy, 6 = slot-2 receive busy.
- R2: A write to address 1 stores bits 19:0 of the bus word and clears flag bit 1. Bus bits above 19 are dropped. The write starts no codec request.
- R3: A write to address 0, made while no command is pending, stores the word and clears flag bit 0. The codec request rises in the next cycle. The request carries the address from word bits 18:12 and is a read when word bit 19 is 1, or a write when bit 19 is 0.
- R4: The codec write data is bits 19:4 of the slot-2 word, as staged when the command starts.
- R5: The request, address, direction and data stay stable until the acknowledge arrives. The cycle after the acknowledge, the request is low and flag bits 0, 1 and 2 are set.
- R6: While a read command is pending, flag bits 5 and 6 are set. Both bits clear when the read completes.
- R7: When a read completes, the slot-1 receive word becomes the slot-1 transmit word with bit 19 cleared. The slot-2 receive word becomes the returned 16-bit data shifted left by 4. Flag bits 3 and 4 are set.
- R8: A write command leaves both receive words and flag bits 3 and 4 unchanged.
- R9: Reading address 2 clears flag bit 3, and reading address 3 clears flag bit 4. Each clear touches only its own bit.
- R10: A write to address 0 while a command is pending is dropped. It changes neither the stored slot-1 word nor the pending command, and it starts no second command.
- R11: Flag bit 2 is set exactly when flag bits 0 and 1 are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (consumes receive slots) |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from reg_addr_i |
| cdc_req_o | output | 1 | Codec command request |
| cdc_rnw_o | output | 1 | Codec command direction, 1 = read |
| cdc_addr_o | output | 7 | Codec register address |
| cdc_wdata_o | output | 16 | Codec write data |
| cdc_ack_i | input | 1 | Codec acknowledge, one cycle |
| cdc_rdata_i | input | 16 | Codec read data, valid with acknowledge |

## Verification
The embedded properties check the codec handshake on every cycle. The command must stay stable while the request waits, the request must drop after the acknowledge, the busy flags must cover a pending read, and the receive words must hold between read completions. The same properties also confirm that slot-2 writes start nothing and that the slot-1 word stays frozen while a command is in flight. Only the bench scenarios show the field extraction for concrete words: the address and data slicing, the clearing of bit 19 and the shift of returned data. They also show the exact flags value after each step and that each receive read clears only its own valid bit.

// File: rtl/ccb_pkg.sv
package ccb_pkg;
  localparam int SLOT_W = 20;
  localparam int CA_W   = 7;
  localparam int CD_W   = 16;
  localparam int BUS_W  = 32;
  localparam int REG_AW = 3;

  typedef enum logic [2:0] {
    RA_S1_TX = 3'd0,
    RA_S2_TX = 3'd1,
    RA_S1_RX = 3'd2,
    RA_S2_RX = 3'd3,
    RA_FLAGS = 3'd4
  } reg_addr_e;

  // packed MSB first: s1_tx_empty lands on bit 0
  typedef struct packed {
    logic s2_rx_busy;
    logic s1_rx_busy;
    logic s2_rx_valid;
    logic s1_rx_valid;
    logic both_tx_empty;
    logic s2_tx_empty;
    logic s1_tx_empty;
  } slot_flags_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } cmd_state_e;
endpackage

// File: rtl/ccb_slot_regs.sv
module ccb_slot_regs #(
  parameter int SLOT_W  = 20,
  parameter int CD_W    = 16,
  parameter int DIR_BIT = 19,
  parameter int CD_LSB  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              s1_we_i,
  input  logic              s2_we_i,
  input  logic [SLOT_W-1:0] wdata_i,
  input  logic              done_rd_i,
  input  logic [CD_W-1:0]   codec_rdata_i,
  output logic [SLOT_W-1:0] s1_tx_o,
  output logic [SLOT_W-1:0] s2_tx_o,
  output logic [SLOT_W-1:0] s1_rx_o,
  output logic [SLOT_W-1:0] s2_rx_o
);
  logic [SLOT_W-1:0] s1_tx_q, s2_tx_q, s1_rx_q, s2_rx_q;
  logic [SLOT_W-1:0] rx1_next, rx2_next;

  always_comb begin
    rx1_next          = s1_tx_q;
    rx1_next[DIR_BIT] = 1'b0;
    rx2_next          = SLOT_W'(codec_rdata_i) << CD_LSB;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_tx_q <= '0;
      s2_tx_q <= '0;
    end else begin
      if (s1_we_i) s1_tx_q <= wdata_i;
      if (s2_we_i) s2_tx_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_rx_q <= '0;
      s2_rx_q <= '0;
    end else if (done_rd_i) begin
      s1_rx_q <= rx1_next;
      s2_rx_q <= rx2_next;
    end
  end

  assign s1_tx_o = s1_tx_q;
  assign s2_tx_o = s2_tx_q;
  assign s1_rx_o = s1_rx_q;
  assign s2_rx_o = s2_rx_q;

  p_rx_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_rd_i |=> ($stable(s1_rx_q) && $stable(s2_rx_q)))
    else $error("receive slots changed without read completion");

  p_rx1_dir_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_rd_i |=> !s1_rx_q[DIR_BIT])
    else $error("direction bit left set in slot-1 receive word");
endmodule

// File: rtl/ccb_cmd_fsm.sv
module ccb_cmd_fsm
  import ccb_pkg::*;
#(
  parameter int CA_W = 7,
  parameter int CD_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            launch_i,
  input  logic            rnw_i,
  input  logic [CA_W-1:0] addr_i,
  input  logic [CD_W-1:0] wdata_i,
  input  logic            ack_i,
  output logic            req_o,
  output logic            rnw_o,
  output logic [CA_W-1:0] addr_o,
  output logic [CD_W-1:0] wdata_o,
  output logic            idle_o,
  output logic            done_o,
  output logic            done_rd_o
);
  cmd_state_e      state_q;
  logic            rnw_q;
  logic [CA_W-1:0] addr_q;
  logic [CD_W-1:0] wdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rnw_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (launch_i) begin
          state_q <= ST_WAIT;
          rnw_q   <= rnw_i;
          addr_q  <= addr_i;
          wdata_q <= wdata_i;
        end
        ST_WAIT: if (ack_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_o     = (state_q == ST_WAIT);
  assign idle_o    = (state_q == ST_IDLE);
  assign rnw_o     = rnw_q;
  assign addr_o    = addr_q;
  assign wdata_o   = wdata_q;
  assign done_o    = req_o && ack_i;
  assign done_rd_o = done_o && rnw_q;

  p_req_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !ack_i) |=> (req_o && $stable(addr_o) && $stable(rnw_o) && $stable(wdata_o)))
    else $error("request dropped or changed before acknowledge");

  p_ack_drop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && ack_i) |=> !req_o)
    else $error("request still high after acknowledge");
endmodule

// File: rtl/ccb_slot_flags.sv
module ccb_slot_flags
  import ccb_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        s1_we_i,
  input  logic        s2_we_i,
  input  logic        launch_rd_i,
  input  logic        done_i,
  input  logic        done_rd_i,
  input  logic        rd_rx1_i,
  input  logic        rd_rx2_i,
  output slot_flags_t flags_o
);
  slot_flags_t flags_q, flags_d;

  always_comb begin
    flags_d = flags_q;
    // transmit slots: a fresh write beats the acknowledge
    if (s1_we_i)     flags_d.s1_tx_empty = 1'b0;
    else if (done_i) flags_d.s1_tx_empty = 1'b1;
    if (s2_we_i)     flags_d.s2_tx_empty = 1'b0;
    else if (done_i) flags_d.s2_tx_empty = 1'b1;
    flags_d.both_tx_empty = flags_d.s1_tx_empty && flags_d.s2_tx_empty;
    // receive slots: completion beats a consuming read
    if (done_rd_i) begin
      flags_d.s1_rx_valid = 1'b1;
      flags_d.s2_rx_valid = 1'b1;
    end else begin
      if (rd_rx1_i) flags_d.s1_rx_valid = 1'b0;
      if (rd_rx2_i) flags_d.s2_rx_valid = 1'b0;
    end
    if (launch_rd_i) begin
      flags_d.s1_rx_busy = 1'b1;
      flags_d.s2_rx_busy = 1'b1;
    end else if (done_rd_i) begin
      flags_d.s1_rx_busy = 1'b0;
      flags_d.s2_rx_busy = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q               <= '0;
      flags_q.s1_tx_empty   <= 1'b1;
      flags_q.s2_tx_empty   <= 1'b1;
      flags_q.both_tx_empty <= 1'b1;
    end else begin
      flags_q <= flags_d;
    end
  end

  assign flags_o = flags_q;

  p_busy_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_q.s1_rx_busy && !done_rd_i) |=> flags_q.s1_rx_busy)
    else $error("receive busy cleared before read completion");

  p_valid_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_rd_i |=> (flags_q.s1_rx_valid && flags_q.s2_rx_valid &&
                   !flags_q.s1_rx_busy && !flags_q.s2_rx_busy))
    else $error("read completion did not update receive flags");

  p_tx_empty_ack_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !s2_we_i) |=> (flags_q.s1_tx_empty && flags_q.s2_tx_empty))
    else $error("transmit empty not restored by acknowledge");
endmodule

// File: rtl/ccb_top.sv
module ccb_top
  import ccb_pkg::*;
#(
  parameter int SLOT_W = ccb_pkg::SLOT_W,
  parameter int CA_W   = ccb_pkg::CA_W,
  parameter int CD_W   = ccb_pkg::CD_W,
  parameter int BUS_W  = ccb_pkg::BUS_W,
  parameter int REG_AW = ccb_pkg::REG_AW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [BUS_W-1:0]  reg_wdata_i,
  output logic [BUS_W-1:0]  reg_rdata_o,
  output logic              cdc_req_o,
  output logic              cdc_rnw_o,
  output logic [CA_W-1:0]   cdc_addr_o,
  output logic [CD_W-1:0]   cdc_wdata_o,
  input  logic              cdc_ack_i,
  input  logic [CD_W-1:0]   cdc_rdata_i
);
  localparam int DIR_BIT = SLOT_W - 1;
  localparam int CA_LSB  = DIR_BIT - CA_W;
  localparam int CD_LSB  = SLOT_W - CD_W;

  logic sel_s1_tx, sel_s2_tx, sel_s1_rx, sel_s2_rx, sel_flags;
  logic s1_we, s2_we, launch, idle, done, done_rd;
  logic [SLOT_W-1:0] s1_tx, s2_tx, s1_rx, s2_rx;
  slot_flags_t flags;

  assign sel_s1_tx = (reg_addr_i == REG_AW'(RA_S1_TX));
  assign sel_s2_tx = (reg_addr_i == REG_AW'(RA_S2_TX));
  assign sel_s1_rx = (reg_addr_i == REG_AW'(RA_S1_RX));
  assign sel_s2_rx = (reg_addr_i == REG_AW'(RA_S2_RX));
  assign sel_flags = (reg_addr_i == REG_AW'(RA_FLAGS));

  // slot-1 writes while a command is in flight are dropped
  assign s1_we  = reg_wr_i && sel_s1_tx && idle;
  assign s2_we  = reg_wr_i && sel_s2_tx;
  assign launch = s1_we;

  ccb_slot_regs #(
    .SLOT_W (SLOT_W),
    .CD_W   (CD_W),
    .DIR_BIT(DIR_BIT),
    .CD_LSB (CD_LSB)
  ) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .s1_we_i      (s1_we),
    .s2_we_i      (s2_we),
    .wdata_i      (reg_wdata_i[SLOT_W-1:0]),
    .done_rd_i    (done_rd),
    .codec_rdata_i(cdc_rdata_i),
    .s1_tx_o      (s1_tx),
    .s2_tx_o      (s2_tx),
    .s1_rx_o      (s1_rx),
    .s2_rx_o      (s2_rx)
  );

  // command fields come straight from the bus word for slot 1, staged word for slot 2
  ccb_cmd_fsm #(
    .CA_W(CA_W),
    .CD_W(CD_W)
  ) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .launch_i (launch),
    .rnw_i    (reg_wdata_i[DIR_BIT]),
    .addr_i   (reg_wdata_i[CA_LSB +: CA_W]),
    .wdata_i  (s2_tx[CD_LSB +: CD_W]),
    .ack_i    (cdc_ack_i),
    .req_o    (cdc_req_o),
    .rnw_o    (cdc_rnw_o),
    .addr_o   (cdc_addr_o),
    .wdata_o  (cdc_wdata_o),
    .idle_o   (idle),
    .done_o   (done),
    .done_rd_o(done_rd)
  );

  ccb_slot_flags u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .s1_we_i    (s1_we),
    .s2_we_i    (s2_we),
    .launch_rd_i(launch && reg_wdata_i[DIR_BIT]),
    .done_i     (done),
    .done_rd_i  (done_rd),
    .rd_rx1_i   (reg_rd_i && sel_s1_rx),
    .rd_rx2_i   (reg_rd_i && sel_s2_rx),
    .flags_o    (flags)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (sel_s1_tx)      reg_rdata_o = BUS_W'(s1_tx);
    else if (sel_s2_tx) reg_rdata_o = BUS_W'(s2_tx);
    else if (sel_s1_rx) reg_rdata_o = BUS_W'(s1_rx);
    else if (sel_s2_rx) reg_rdata_o = BUS_W'(s2_rx);
    else if (sel_flags) reg_rdata_o = BUS_W'(flags);
  end

  p_no_launch_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && sel_s2_tx && !cdc_req_o) |=> !cdc_req_o)
    else $error("slot-2 write started a command");

  p_busy_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cdc_req_o && cdc_rnw_o) |-> (flags.s1_rx_busy && flags.s2_rx_busy))
    else $error("pending read without busy flags");

  p_s1_frozen_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cdc_req_o && !cdc_ack_i) |=> $stable(s1_tx))
    else $error("slot-1 word changed during pending command");
endmodule

// File: tb/ccb_top_bench.sv
module ccb_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        req, rnw, ack = 1'b0;
  logic [6:0]  caddr;
  logic [15:0] cwdata, crdata = '0;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  ccb_top u_ccb_top (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .cdc_req_o(req), .cdc_rnw_o(rnw), .cdc_addr_o(caddr),
    .cdc_wdata_o(cwdata), .cdc_ack_i(ack), .cdc_rdata_i(crdata)
  );

  typedef struct packed {
    logic [19:0] s1;
    logic [19:0] s2;
    logic [15:0] rd;
    logic [6:0]  exp_addr;
    logic        exp_rnw;
    logic [15:0] exp_wdata;
    logic [19:0] exp_rx1;
    logic [19:0] exp_rx2;
  } vec_t;

  localparam int NV = 4;
  localparam vec_t VECS [NV] = '{
    '{20'hA6000, 20'h12345, 16'hBEEF, 7'h26, 1'b1, 16'h1234, 20'h26000, 20'hBEEF0},
    '{20'h02ABC, 20'hFEDCB, 16'h5555, 7'h02, 1'b0, 16'hFEDC, 20'h00000, 20'h00000},
    '{20'hFF00F, 20'h00000, 16'h0001, 7'h7F, 1'b1, 16'h0000, 20'h7F00F, 20'h00010},
    '{20'h00000, 20'h0000F, 16'hFFFF, 7'h00, 1'b0, 16'h0000, 20'h00000, 20'h00000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    rd = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic codec_ack(input logic [15:0] d);
    @(negedge clk);
    ack = 1'b1; crdata = d;
    @(negedge clk);
    ack = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [19:0] prev_rx1, prev_rx2;
    prev_rx1 = '0; prev_rx2 = '0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    reg_read(3'd4, v);
    chk("R1 flags after reset", v, 32'h07);
    chk("R1 no request after reset", {31'b0, req}, 32'h0);

    // R2 / R11: slot-2 staging, upper bus bits dropped, no launch
    reg_write(3'd1, 32'hFFF00ABC);
    repeat (2) @(negedge clk);
    chk("R2 no request after slot-2 write", {31'b0, req}, 32'h0);
    reg_read(3'd1, v);
    chk("R2 slot-2 readback", v, 32'h00ABC);
    reg_read(3'd4, v);
    chk("R11 combined empty follows slots", v, 32'h01);

    // table of commands
    for (int i = 0; i < NV; i++) begin
      reg_write(3'd1, {12'h000, VECS[i].s2});
      reg_write(3'd0, {12'h000, VECS[i].s1});
      chk("R3 request raised", {31'b0, req}, 32'h1);
      chk("R3 codec address", {25'b0, caddr}, {25'b0, VECS[i].exp_addr});
      chk("R3 direction", {31'b0, rnw}, {31'b0, VECS[i].exp_rnw});
      chk("R4 codec write data", {16'b0, cwdata}, {16'b0, VECS[i].exp_wdata});
      reg_read(3'd4, v);
      chk("R6 flags while pending", v, VECS[i].exp_rnw ? 32'h60 : 32'h00);
      repeat (2) @(negedge clk);
      chk("R5 request held", {31'b0, req}, 32'h1);
      chk("R5 address held", {25'b0, caddr}, {25'b0, VECS[i].exp_addr});
      codec_ack(VECS[i].rd);
      chk("R5 request dropped after ack", {31'b0, req}, 32'h0);
      reg_read(3'd4, v);
      chk("R7 flags after completion", v, VECS[i].exp_rnw ? 32'h1F : 32'h07);
      if (VECS[i].exp_rnw) begin
        reg_read(3'd2, v);
        chk("R7 slot-1 receive word", v, {12'h000, VECS[i].exp_rx1});
        reg_read(3'd3, v);
        chk("R7 slot-2 receive word", v, {12'h000, VECS[i].exp_rx2});
        prev_rx1 = VECS[i].exp_rx1;
        prev_rx2 = VECS[i].exp_rx2;
      end else begin
        reg_read(3'd2, v);
        chk("R8 slot-1 receive unchanged", v, {12'h000, prev_rx1});
        reg_read(3'd3, v);
        chk("R8 slot-2 receive unchanged", v, {12'h000, prev_rx2});
      end
    end

    // R10: slot-1 write while pending is dropped; R9: per-slot valid clear
    reg_write(3'd0, 32'h00091000);
    chk("R10 first command address", {25'b0, caddr}, 32'h11);
    reg_write(3'd0, 32'h00005000);
    chk("R10 pending address kept", {25'b0, caddr}, 32'h11);
    chk("R10 pending direction kept", {31'b0, rnw}, 32'h1);
    reg_read(3'd0, v);
    chk("R10 slot-1 word kept", v, 32'h00091000);
    codec_ack(16'hA5A5);
    chk("R10 request dropped", {31'b0, req}, 32'h0);
    @(negedge clk);
    chk("R10 no second command", {31'b0, req}, 32'h0);
    reg_read(3'd4, v);
    chk("R7 flags after read", v, 32'h1F);
    reg_read(3'd2, v);
    chk("R7 slot-1 receive", v, 32'h11000);
    reg_read(3'd4, v);
    chk("R9 slot-1 valid cleared only", v, 32'h17);
    reg_read(3'd3, v);
    chk("R7 slot-2 receive", v, 32'hA5A50);
    reg_read(3'd4, v);
    chk("R9 slot-2 valid cleared", v, 32'h07);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule